// File: doc/BRIEF.md
# Eight-Line Interrupt Controller Host Port and Command Sequencer

This block is the host-side register port of a single eight-input vectored interrupt controller. A host writes and reads it through a one-bit address, separate write and read strobes and an eight-bit data bus. Through that port the host runs a multi-word initialisation sequence, loads the line mask, and issues operation commands. These commands cover end-of-interrupt, priority rotation, read selection, polling and special masking.

Inside, the block keeps the mask, in-service, rotation-base and vector-base registers and the mode flags. Two submodules do the rest. A request-capture stage turns the raw lines into a request register, using either edge or level capture for each line. A rotating-priority picker, instantiated three times, ranks the requests and the in-service bits.

When the processor acknowledges, the block returns a vector in that same cycle and updates its in-service and rotation state on the clock edge. A read while polling is armed acts as an acknowledge without a vector. Cascading several controllers and driving the processor interrupt line are outside this block.

Top module: `intc_cmd_seq`

## Requirements
- R1: After synchronous reset the mask, in-service and request registers read 0. An address-0 read selects the request register. The sequencer is ready, so an address-1 write loads the mask.
- R2: An address-0 write with data bit 4 = 1 starts initialisation. It clears the mask, in-service, edge-captured requests, rotation base, vector base and all mode flags. It stores data bit 0 as the flag that says a fourth word will follow.
- R3: After initialisation starts, the next address-1 write sets the vector base to data AND 0xF8. The following address-1 write is taken as the cascade word and ignored. A fourth address-1 write is consumed only if flagged. Any address-1 write after that loads the mask.
- R4: The fourth word sets special nested mode from bit 4 and auto end-of-interrupt from bit 1. In special nested mode the in-service bit of line 2 does not block other requests.
- R5: A line whose trig_level bit is 0 latches a request on a 0-to-1 transition, and the request stays set until it is acknowledged or polled. A line whose trig_level bit is 1 mirrors its input into the request register one clock later, and acknowledge does not clear it.
- R6: The line at the rotation base has the highest priority, and priority falls cyclically upward from there. An unmasked request wins only if it ranks strictly ahead of the highest-ranked in-service bit. In special mask mode, masked in-service bits do not block.
- R7: While ack is high, ack_vector = vector base + winning line, or vector base + 7 if no line wins. On that clock edge the winner's in-service bit is set (unless auto end-of-interrupt is on) and its edge request is cleared.
- R8: Under auto end-of-interrupt an acknowledge sets no in-service bit. If rotate-on-auto-EOI is on, the rotation base becomes winner + 1 (mod 8).
- R9: An address-0 write with bit 4 = 0 and bit 3 = 1 is a read/poll command. Bit 2 = 1 arms poll. Bit 1 = 1 lets bit 0 select the in-service register (1) or the request register (0). Bit 6 = 1 sets special mask mode to bit 5.
- R10: Other address-0 writes decode command = data[7:5]. Command 1 clears the highest-ranked in-service bit. Command 5 clears that bit and sets the rotation base to it + 1. Command 3 clears in-service bit data[2:0]. Command 7 clears in-service bit data[2:0] and sets the rotation base to data[2:0] + 1.
- R11: Command 6 sets the rotation base to data[2:0] + 1. Command 0 clears rotate-on-auto-EOI and command 4 sets it. Command 2 changes nothing.
- R12: A read while poll is armed returns the winning line number and clears that line's request and in-service bits. If no line wins, the read returns 7. Either way poll is disarmed after the read.
- R13: A non-poll read returns data in the same cycle as rd_en. At address 0 it returns the selected in-service or request register, and at address 1 it returns the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Raw interrupt request lines |
| trig_level | input | 8 | Per-line capture select: 1 = level, 0 = rising edge |
| addr | input | 1 | Register address |
| wr_en | input | 1 | Write strobe, acted on at the clock edge |
| rd_en | input | 1 | Read strobe; poll side effects at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| ack | input | 1 | Interrupt acknowledge strobe |
| ack_vector | output | 8 | Vector returned during ack |

## Verification
Read data and ack_vector are combinational, so the bench samples them 2 ns after the falling edge that raised the strobe, in the same cycle. Register effects of a write, acknowledge or poll read appear after the following rising edge, so the bench looks at them only in its next operation. A change on irq_in reaches the request register after one rising edge, and the bench waits one full cycle after driving the lines before any check. Every expected value comes from a bench-side model that is updated in this same order. Near-exhaustive sweeps cover all eight rotation bases with several request patterns, and each acknowledge is checked until nothing is left pending.

// File: rtl/intc_pkg.sv
// Shared types and command-word bit positions for the interrupt controller
// host port. The bit positions are fixed by the eight-bit command format.
package intc_pkg;

    // Initialisation sequencer state.
    typedef enum logic [1:0] {
        SEQ_READY = 2'd0,
        SEQ_BASE  = 2'd1,
        SEQ_CASC  = 2'd2,
        SEQ_MODE  = 2'd3
    } seq_state_t;

    // Operation command codes carried in data[7:5].
    typedef enum logic [2:0] {
        CMD_RAEOI_CLR  = 3'd0,
        CMD_EOI_TOP    = 3'd1,
        CMD_NOP        = 3'd2,
        CMD_EOI_LINE   = 3'd3,
        CMD_RAEOI_SET  = 3'd4,
        CMD_EOI_TOP_RT = 3'd5,
        CMD_SET_BASE   = 3'd6,
        CMD_EOI_LINE_RT = 3'd7
    } op_cmd_t;

    localparam int B_INIT    = 4;  // address 0: start initialisation
    localparam int B_READCMD = 3;  // address 0: read/poll command
    localparam int B_POLL    = 2;
    localparam int B_RSEL_EN = 1;
    localparam int B_RSEL    = 0;
    localparam int B_SMM_EN  = 6;
    localparam int B_SMM     = 5;
    localparam int B_NEED4   = 0;  // init word: fourth word follows
    localparam int B_NEST    = 4;  // fourth word: special nested
    localparam int B_AEOI    = 1;  // fourth word: auto end-of-interrupt
    localparam int CMD_LSB   = 5;

endpackage

// File: rtl/intc_prio_pick.sv
// Rotating priority picker.
// Finds the first set bit of vec, scanning from position base upward and
// wrapping. Reports the bit index and its rank (distance from base).
// Assumes NLINES is a power of two so index arithmetic wraps naturally.
module intc_prio_pick #(
    parameter int NLINES = 8,
    localparam int IDW   = $clog2(NLINES)
) (
    input  logic [NLINES-1:0] vec,
    input  logic [IDW-1:0]    base,
    output logic              found,
    output logic [IDW-1:0]    idx,
    output logic [IDW-1:0]    rank
);

    logic [IDW-1:0] pos;

    // Scan from worst rank to best so the best-ranked set bit is kept last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        rank  = '0;
        pos   = '0;
        for (int r = NLINES - 1; r >= 0; r--) begin
            pos = base + IDW'(r);
            if (vec[pos]) begin
                found = 1'b1;
                idx   = pos;
                rank  = IDW'(r);
            end
        end
    end

endmodule

// File: rtl/intc_req_capture.sv
// Request capture stage.
// Per line: level mode mirrors the input; edge mode latches a 0->1
// transition and holds it until cleared. Assumes clear requests and new
// edges seldom coincide; when they do, the new edge wins.
module intc_req_capture #(
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic [NLINES-1:0] trig_level,
    input  logic              init_clr,
    input  logic [NLINES-1:0] req_clr,
    output logic [NLINES-1:0] irr
);

    logic [NLINES-1:0] last_q;
    logic [NLINES-1:0] irr_q;
    logic [NLINES-1:0] rise;
    logic [NLINES-1:0] edge_next;

    // Edge detection and next value of the edge-captured requests.
    always_comb begin
        rise      = irq_in & ~last_q;
        edge_next = init_clr ? '0 : ((irr_q & ~req_clr) | rise);
    end

    // Input history and request register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            irr_q  <= '0;
        end else begin
            last_q <= irq_in;
            irr_q  <= (trig_level & irq_in) | (~trig_level & edge_next);
        end
    end

    assign irr = irr_q;

    for (genvar i = 0; i < NLINES; i++) begin : g_line_chk
        // R5: an edge-mode line latches a request after a rising input
        p_edge_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_level[i] && irq_in[i] && !last_q[i] && !init_clr) |=> irr_q[i]);
        // R5: a level-mode line follows its input one clock later
        p_level_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
            trig_level[i] |=> (irr_q[i] == $past(irq_in[i])));
    end

endmodule

// File: rtl/intc_cmd_seq.sv
// Host port and command sequencer of an eight-input interrupt controller.
// Runs the initialisation word sequence, decodes operation commands, holds
// mask / in-service / rotation / vector-base state and serves register,
// poll and acknowledge accesses. Assumes wr_en, ack and rd_en are not
// raised together; if they are, the write wins, then ack, then read.
module intc_cmd_seq
    import intc_pkg::*;
#(
    parameter int NLINES       = 8,
    parameter int DATA_W       = 8,
    parameter int CASCADE_LINE = 2,
    localparam int IDW         = $clog2(NLINES),
    localparam int NPICK       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic [NLINES-1:0] trig_level,
    input  logic              addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ack,
    output logic [DATA_W-1:0] ack_vector
);

    localparam logic [NLINES-1:0] CASC_BIT = NLINES'(1) << CASCADE_LINE;

    seq_state_t        seq_q;
    logic [NLINES-1:0] imr_q;
    logic [NLINES-1:0] isr_q;
    logic [IDW-1:0]    rot_q;
    logic [DATA_W-1:0] vbase_q;
    logic              need4_q;
    logic              rd_isr_q;
    logic              poll_q;
    logic              smm_q;
    logic              aeoi_q;
    logic              rot_aeoi_q;
    logic              nest_q;

    logic [NLINES-1:0] irr;
    logic [NLINES-1:0] req_vec;
    logic [NLINES-1:0] eff_isr;
    logic [NLINES-1:0] pick_vec   [NPICK];
    logic              pick_found [NPICK];
    logic [IDW-1:0]    pick_idx   [NPICK];
    logic [IDW-1:0]    pick_rank  [NPICK];
    logic              pend;
    logic [IDW-1:0]    win_id;
    logic [NLINES-1:0] win_bit;
    logic              init_wr;
    logic              take_ack;
    logic              take_poll;
    logic [NLINES-1:0] req_clr;
    op_cmd_t           cmd;

    // Request capture stage.
    intc_req_capture #(.NLINES(NLINES)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .trig_level(trig_level),
        .init_clr  (init_wr),
        .req_clr   (req_clr),
        .irr       (irr)
    );

    // Vectors the pickers rank: live requests, blocking in-service, raw in-service.
    always_comb begin
        req_vec = irr & ~imr_q;
        eff_isr = isr_q;
        if (nest_q) eff_isr = eff_isr & ~CASC_BIT;
        if (smm_q)  eff_isr = eff_isr & ~imr_q;
        pick_vec[0] = req_vec;
        pick_vec[1] = eff_isr;
        pick_vec[2] = isr_q;
    end

    for (genvar k = 0; k < NPICK; k++) begin : g_pick
        intc_prio_pick #(.NLINES(NLINES)) u_pick (
            .vec  (pick_vec[k]),
            .base (rot_q),
            .found(pick_found[k]),
            .idx  (pick_idx[k]),
            .rank (pick_rank[k])
        );
        // R6: a picker only reports a set bit, at its rotated rank
        p_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
            pick_found[k] |-> (pick_vec[k][pick_idx[k]] &&
                               (IDW'(pick_idx[k] - rot_q) == pick_rank[k])));
    end

    // Winner selection and strobe qualification.
    always_comb begin
        pend      = pick_found[0] && (!pick_found[1] || (pick_rank[0] < pick_rank[1]));
        win_id    = pend ? pick_idx[0] : '1;
        win_bit   = NLINES'(1) << pick_idx[0];
        init_wr   = wr_en && !addr && wdata[B_INIT];
        take_ack  = ack && !wr_en;
        take_poll = rd_en && !wr_en && !ack && poll_q;
        req_clr   = ((take_ack || take_poll) && pend) ? win_bit : '0;
        cmd       = op_cmd_t'(wdata[CMD_LSB +: 3]);
    end

    // Acknowledge vector, valid while ack is high.
    assign ack_vector = vbase_q | DATA_W'(win_id);

    // Read data mux, valid while rd_en is high.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (poll_q)        rdata = DATA_W'(win_id);
            else if (addr)     rdata = DATA_W'(imr_q);
            else if (rd_isr_q) rdata = DATA_W'(isr_q);
            else               rdata = DATA_W'(irr);
        end
    end

    // Control state: init sequence, commands, acknowledge and poll effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q      <= SEQ_READY;
            imr_q      <= '0;
            isr_q      <= '0;
            rot_q      <= '0;
            vbase_q    <= '0;
            need4_q    <= 1'b0;
            rd_isr_q   <= 1'b0;
            poll_q     <= 1'b0;
            smm_q      <= 1'b0;
            aeoi_q     <= 1'b0;
            rot_aeoi_q <= 1'b0;
            nest_q     <= 1'b0;
        end else if (wr_en && !addr) begin
            if (wdata[B_INIT]) begin
                seq_q      <= SEQ_BASE;
                imr_q      <= '0;
                isr_q      <= '0;
                rot_q      <= '0;
                vbase_q    <= '0;
                need4_q    <= wdata[B_NEED4];
                rd_isr_q   <= 1'b0;
                poll_q     <= 1'b0;
                smm_q      <= 1'b0;
                aeoi_q     <= 1'b0;
                rot_aeoi_q <= 1'b0;
                nest_q     <= 1'b0;
            end else if (wdata[B_READCMD]) begin
                if (wdata[B_POLL])    poll_q   <= 1'b1;
                if (wdata[B_RSEL_EN]) rd_isr_q <= wdata[B_RSEL];
                if (wdata[B_SMM_EN])  smm_q    <= wdata[B_SMM];
            end else begin
                case (cmd)
                    CMD_RAEOI_CLR, CMD_RAEOI_SET: rot_aeoi_q <= cmd[2];
                    CMD_EOI_TOP, CMD_EOI_TOP_RT: begin
                        if (pick_found[2]) begin
                            isr_q[pick_idx[2]] <= 1'b0;
                            if (cmd == CMD_EOI_TOP_RT) rot_q <= pick_idx[2] + 1'b1;
                        end
                    end
                    CMD_EOI_LINE: isr_q[wdata[IDW-1:0]] <= 1'b0;
                    CMD_SET_BASE: rot_q <= wdata[IDW-1:0] + 1'b1;
                    CMD_EOI_LINE_RT: begin
                        isr_q[wdata[IDW-1:0]] <= 1'b0;
                        rot_q <= wdata[IDW-1:0] + 1'b1;
                    end
                    default: ;
                endcase
            end
        end else if (wr_en) begin
            case (seq_q)
                SEQ_READY: imr_q <= wdata[NLINES-1:0];
                SEQ_BASE: begin
                    vbase_q <= {wdata[DATA_W-1:IDW], IDW'(0)};
                    seq_q   <= SEQ_CASC;
                end
                SEQ_CASC: seq_q <= need4_q ? SEQ_MODE : SEQ_READY;
                SEQ_MODE: begin
                    nest_q <= wdata[B_NEST];
                    aeoi_q <= wdata[B_AEOI];
                    seq_q  <= SEQ_READY;
                end
                default: seq_q <= SEQ_READY;
            endcase
        end else if (take_ack) begin
            if (pend) begin
                if (!aeoi_q)         isr_q[win_id] <= 1'b1;
                else if (rot_aeoi_q) rot_q <= win_id + 1'b1;
            end
        end else if (take_poll) begin
            poll_q <= 1'b0;
            if (pend) isr_q[win_id] <= 1'b0;
        end
    end

    // R2: starting initialisation empties mask and in-service and awaits the base word
    p_init_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (imr_q == '0 && isr_q == '0 && seq_q == SEQ_BASE));
    // R3: outside initialisation an address-1 write loads the mask
    p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && seq_q == SEQ_READY) |=> (imr_q == $past(wdata[NLINES-1:0])));
    // R7: acknowledge without auto end-of-interrupt marks the winner in service
    p_ack_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ack && pend && !aeoi_q) |=> isr_q[$past(win_id)]);
    // R8: acknowledge under auto end-of-interrupt leaves in-service untouched
    p_aeoi_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ack && aeoi_q) |=> $stable(isr_q));
    // R10: command 7 moves the rotation base past the named line
    p_rot_cmd7_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && !wdata[B_INIT] && !wdata[B_READCMD] && cmd == CMD_EOI_LINE_RT)
        |=> (rot_q == IDW'($past(wdata[IDW-1:0]) + 1'b1)));
    // R12: a poll read always disarms poll
    p_poll_disarm_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take_poll |=> !poll_q);

endmodule

// File: tb/tb_intc_cmd_seq.sv
`timescale 1ns/1ps
module tb_intc_cmd_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic [7:0] trig_level = 8'h40;
    logic       addr = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ack = 1'b0;
    logic [7:0] ack_vector;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench-side model of the controller.
    logic [7:0] m_irr = '0, m_imr = '0, m_isr = '0, m_lines = '0, m_base = '0;
    int         m_rot = 0, m_st = 0;
    bit         m_need4 = 0, m_rdisr = 0, m_poll = 0, m_smm = 0;
    bit         m_aeoi = 0, m_raeoi = 0, m_nest = 0;

    intc_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_level(trig_level),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .ack(ack), .ack_vector(ack_vector)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic void m_sync();
        m_irr = (m_irr & ~trig_level) | (m_lines & trig_level);
    endfunction

    // Model winner: -1 when no request ranks ahead of blocking in-service.
    function automatic int m_win();
        logic [7:0] eff, req;
        eff = m_isr;
        if (m_nest) eff[2] = 1'b0;
        if (m_smm)  eff = eff & ~m_imr;
        req = m_irr & ~m_imr;
        for (int r = 0; r < 8; r++) begin
            int i;
            i = (m_rot + r) % 8;
            if (eff[i]) return -1;
            if (req[i]) return i;
        end
        return -1;
    endfunction

    function automatic int m_top_isr();
        for (int r = 0; r < 8; r++) begin
            if (m_isr[(m_rot + r) % 8]) return (m_rot + r) % 8;
        end
        return -1;
    endfunction

    task automatic set_lines(logic [7:0] v);
        m_irr   = m_irr | (v & ~m_lines & ~trig_level);
        m_lines = v;
        m_sync();
        @(negedge clk); irq_in = v;
        @(negedge clk);
    endtask

    task automatic wr(bit a, logic [7:0] d);
        int t;
        if (!a) begin
            if (d[4]) begin
                m_imr = 0; m_isr = 0; m_irr = 0; m_rot = 0; m_base = 0;
                m_rdisr = 0; m_poll = 0; m_smm = 0; m_aeoi = 0; m_raeoi = 0;
                m_nest = 0; m_need4 = d[0]; m_st = 1;
            end else if (d[3]) begin
                if (d[2]) m_poll = 1;
                if (d[1]) m_rdisr = d[0];
                if (d[6]) m_smm = d[5];
            end else begin
                case (d[7:5])
                    3'd0, 3'd4: m_raeoi = d[7];
                    3'd1, 3'd5: begin
                        t = m_top_isr();
                        if (t >= 0) begin
                            m_isr[t] = 1'b0;
                            if (d[7]) m_rot = (t + 1) % 8;
                        end
                    end
                    3'd3: m_isr[d[2:0]] = 1'b0;
                    3'd6: m_rot = (d[2:0] + 1) % 8;
                    3'd7: begin m_isr[d[2:0]] = 1'b0; m_rot = (d[2:0] + 1) % 8; end
                    default: ;
                endcase
            end
        end else begin
            case (m_st)
                0: m_imr = d;
                1: begin m_base = d & 8'hF8; m_st = 2; end
                2: m_st = m_need4 ? 3 : 0;
                default: begin m_nest = d[4]; m_aeoi = d[1]; m_st = 0; end
            endcase
        end
        m_sync();
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(bit a, string tag);
        logic [7:0] exp;
        int w;
        if (m_poll) begin
            w = m_win();
            exp = (w < 0) ? 8'd7 : 8'(w);
            if (w >= 0) begin m_irr[w] = 1'b0; m_isr[w] = 1'b0; end
            m_poll = 0;
            m_sync();
        end else if (a) exp = m_imr;
        else exp = m_rdisr ? m_isr : m_irr;
        @(negedge clk); addr = a; rd_en = 1'b1;
        #2 check(tag, rdata, exp);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ack_chk(string tag);
        logic [7:0] exp;
        int w;
        w = m_win();
        exp = m_base | ((w < 0) ? 8'd7 : 8'(w));
        if (w >= 0) begin
            if (m_aeoi) begin if (m_raeoi) m_rot = (w + 1) % 8; end
            else m_isr[w] = 1'b1;
            if (!trig_level[w]) m_irr[w] = 1'b0;
        end
        @(negedge clk); ack = 1'b1;
        #2 check(tag, ack_vector, exp);
        @(negedge clk); ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk(0, "R1 request reg after reset");
        rd_chk(1, "R1 mask after reset");
        wr(1, 8'h5A);
        rd_chk(1, "R1 ready sequencer loads mask");

        // R2/R3: init without fourth word
        wr(0, 8'h10);
        rd_chk(1, "R2 init clears mask");
        wr(1, 8'h23); wr(1, 8'h00); wr(1, 8'hFF);
        rd_chk(1, "R3 third word ends sequence without fourth");
        wr(1, 8'h00);
        set_lines(8'h01);
        check("R3 vector base expected literal", m_base, 8'h20);
        ack_chk("R3 vector base masked to 0xF8");
        wr(0, 8'h20);
        set_lines(8'h00);

        // R3/R4: init with fourth word; fourth word must not load the mask
        wr(0, 8'h11); wr(1, 8'h48); wr(1, 8'h04); wr(1, 8'h01);
        rd_chk(1, "R3 fourth word not taken as mask");

        // R5, R7, R13, R6, R10
        set_lines(8'h28);
        rd_chk(0, "R5 edge requests latched");
        ack_chk("R7 ack returns highest priority line");
        wr(0, 8'h0B);
        rd_chk(0, "R13 in-service read");
        wr(0, 8'h0A);
        rd_chk(0, "R7 ack clears edge request");
        ack_chk("R6 lower line blocked by in-service");
        wr(0, 8'h20);
        wr(0, 8'h0B);
        rd_chk(0, "R10 command 1 clears top in-service");
        ack_chk("R7 pending line acknowledged after EOI");
        wr(0, 8'h65);
        rd_chk(0, "R10 command 3 clears named in-service");

        // R12: poll
        set_lines(8'h00); set_lines(8'h12);
        wr(0, 8'h0C);
        rd_chk(0, "R12 poll returns winner");
        rd_chk(0, "R12 poll disarmed after read");
        wr(0, 8'h0A);
        rd_chk(0, "R12 poll cleared request");
        wr(0, 8'h0C);
        rd_chk(1, "R12 second poll winner");
        wr(0, 8'h0C);
        rd_chk(0, "R12 poll with nothing pending returns 7");

        // R10: rotating EOI commands
        set_lines(8'h00); set_lines(8'h81);
        ack_chk("R10 setup ack");
        wr(0, 8'hA0);
        ack_chk("R10 command 5 rotates base");
        wr(0, 8'hE7);
        wr(0, 8'h0B);
        rd_chk(0, "R10 command 7 clears in-service");
        set_lines(8'h00); set_lines(8'h03);
        ack_chk("R10 setup ack line 0");
        wr(0, 8'hE0);
        ack_chk("R10 command 7 rotation base");
        wr(0, 8'h20);

        // R11: no-op and base set
        set_lines(8'h00); set_lines(8'h04);
        ack_chk("R11 setup ack");
        wr(0, 8'h40);
        rd_chk(0, "R11 command 2 leaves in-service");
        wr(0, 8'h62);
        wr(0, 8'hC4);
        set_lines(8'h00); set_lines(8'h21);
        ack_chk("R11 command 6 sets base");
        ack_chk("R11 line behind base blocked");
        wr(0, 8'h65);
        ack_chk("R11 line released after EOI");
        wr(0, 8'h20);
        wr(0, 8'hC7);

        // R4/R6/R8: auto-EOI sweeps over all rotation bases
        set_lines(8'h00);
        wr(0, 8'h11); wr(1, 8'h80); wr(1, 8'h00); wr(1, 8'h02);
        for (int b = 0; b < 8; b++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] pat;
                pat = 8'((8'h5B * (p + 1) + b * 8'h11) & 8'hBF);
                wr(1, (p == 3) ? 8'hC1 : 8'h40);
                set_lines(8'h00);
                wr(0, 8'(8'hC0 | ((b + 7) % 8)));
                set_lines(pat);
                for (int k = 0; k < 9; k++) ack_chk("R6 sweep under auto-EOI (R4)");
            end
        end
        wr(0, 8'h0B);
        rd_chk(0, "R8 no in-service under auto-EOI");

        // R8/R11: rotate-on-auto-EOI on and off
        wr(1, 8'h40); wr(0, 8'hC7);
        wr(0, 8'h80);
        set_lines(8'h00); set_lines(8'h03);
        ack_chk("R8 rotate on auto-EOI first");
        set_lines(8'h02); set_lines(8'h03);
        ack_chk("R8 rotated base picks line 1");
        ack_chk("R8 then line 0");
        wr(0, 8'h00); wr(0, 8'hC7);
        set_lines(8'h00); set_lines(8'h03);
        ack_chk("R11 command 0 first ack");
        set_lines(8'h02); set_lines(8'h03);
        ack_chk("R11 command 0 stops rotation");

        // R5: level-mode line
        wr(1, 8'h00);
        set_lines(8'h00); set_lines(8'h40);
        wr(0, 8'h0A);
        rd_chk(0, "R5 level line sets request");
        ack_chk("R5 level ack");
        ack_chk("R5 level request not cleared by ack");
        set_lines(8'h00);
        rd_chk(0, "R5 level request follows input low");

        // R4: special nested mode
        wr(0, 8'h11); wr(1, 8'h08); wr(1, 8'h00); wr(1, 8'h10);
        set_lines(8'h04);
        ack_chk("R4 nested setup ack line 2");
        set_lines(8'h14);
        ack_chk("R4 special nested ignores line 2 in-service");
        wr(0, 8'h64); wr(0, 8'h62);

        // R9: special mask mode
        set_lines(8'h00);
        wr(0, 8'h11); wr(1, 8'h08); wr(1, 8'h00); wr(1, 8'h00);
        set_lines(8'h02);
        ack_chk("R9 setup ack line 1");
        wr(1, 8'h02);
        set_lines(8'h22);
        ack_chk("R9 blocked without special mask");
        wr(0, 8'h68);
        ack_chk("R9 special mask releases lower line");
        wr(0, 8'h48);
        wr(0, 8'h0B);
        rd_chk(0, "R9 in-service after special mask");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule